// File: doc/BRIEF.md
# Page-Wrapping Word Pointer and Write Buffer for a Serial EEPROM

This block sits behind a byte-level two-wire slave front end. It tracks the word pointer of a 256-byte array that is split into sixteen 16-byte rows, and it decides which received bytes are acknowledged. On a write it loads the pointer from the word-address byte. Each data byte then goes into a one-row buffer, and the buffer keeps a mask of the slots that actually arrived. The buffer is written to the array only when a stop closes the transfer.

After that commit the block stays busy for a self-timed interval. During this interval it refuses device-address bytes, so a master can poll for completion. On a read, each byte request returns the array byte at the pointer, and the pointer then advances.

The pointer rolls over differently for the two directions. Writes wrap inside the current row. Reads wrap across the whole 8-bit space. The pointer keeps its value between transfers, so a read that sends no address starts where the previous access stopped. The array itself lives outside the block and is reached through a plain address, write-enable and data port.

Top module: `ee_ptr_ctrl`

## Requirements
- R1: After reset ack_o, rd_vld_o and mem_we_o are 0, the block is not busy, and the pointer is 00h, so a read that sends no address returns array byte 00h.
- R2: The first byte after start_i is a device byte. Bits [7:4] must equal DEV_CODE (default 1010b) and bits [3:1] must equal sel_i. Bit 0 selects the direction: 1 is a read, 0 is a write. A matching device byte is acknowledged when the block is not busy. Any other device byte is not acknowledged, and every byte after it is ignored and not acknowledged until the next start_i.
- R3: On a write, the byte after the device byte is acknowledged and loads all 8 pointer bits.
- R4: On a write, each data byte is acknowledged and stored at the pointer. After that, only pointer bits [3:0] increment, modulo 16, and bits [7:4] stay fixed. A 17th byte therefore replaces the first byte written in the same row.
- R5: A partial row write changes only the slots that received a byte. All other array bytes keep their values.
- R6: The buffered data reaches the array only when stop_i ends a write that carried at least one data byte. A repeated start_i throws the buffered data away. A stop after only the word-address byte starts no write cycle.
- R7: After a commit, a matching device byte is not acknowledged for at least WR_CYCLES clock cycles. It is acknowledged again within 16 + WR_CYCLES + 4 cycles of the stop.
- R8: In read mode, each rd_req_i pulse gives rd_vld_o and rd_data_o one cycle later. rd_data_o holds the array byte at the pointer, and the pointer then increments over all 8 bits, from FFh to 00h.
- R9: The pointer keeps its value between transfers: the last written address + 1 within its row, or the last read address + 1. A read with no address sent starts from that value.
- R10: A random read is a write of the word address only, then a repeated start_i and a read device byte. It returns data starting at the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Strapped select bits compared with device-byte bits [3:1] |
| start_i | input | 1 | One-cycle strobe for a start or repeated start |
| stop_i | input | 1 | One-cycle strobe for a stop |
| byte_vld_i | input | 1 | One-cycle strobe: byte_i holds a received byte |
| byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Front end asks for the next byte to transmit |
| ack_o | output | 1 | Acknowledge decision for the last received byte, valid one cycle after byte_vld_i |
| rd_vld_o | output | 1 | rd_data_o is valid |
| rd_data_o | output | 8 | Byte to transmit |
| mem_addr_o | output | 8 | Array address |
| mem_we_o | output | 1 | Array write enable |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data for mem_addr_o, combinational |

## Verification
Directed cases cover:
- a 20-byte row write starting mid-row, which separates row-local wrap from a plain 8-bit increment;
- a three-byte partial write, which shows whether untouched slots survive;
- a read running through FFh, which shows a full-space wrap;
- mismatched select bits and a wrong device code;
- a repeated start after data, and a stop after only the word-address byte, which separate "commit on stop" from "commit on any end".

A poll at a fixed early point and one after the deadline bound the busy window from both sides. Random writes of 1 to 20 bytes and random reads of 1 to 8 bytes are mixed with current-address reads, and every byte read back is compared with a bench model of the array and the pointer.

// File: rtl/ee_ptr_pkg.sv
package ee_ptr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_READ
  } seq_st_e;
endpackage

// File: rtl/ee_addr_ptr.sv
module ee_addr_ptr #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_wr_i,
  input  logic              inc_rd_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [PAGE_W-1:0] ONE_P = PAGE_W'(1);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (load_i)   ptr_q <= load_val_i;
    else if (inc_wr_i) ptr_q <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + ONE_P};
    else if (inc_rd_i) ptr_q <= ptr_q + ONE_A;
  end

  assign ptr_o = ptr_q;

  AST_WR_ROW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_wr_i && !load_i |=> ptr_o[ADDR_W-1:PAGE_W] == $past(ptr_o[ADDR_W-1:PAGE_W])); // R4
  AST_WR_LOW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_wr_i && !load_i |=> ptr_o[PAGE_W-1:0] == $past(ptr_o[PAGE_W-1:0]) + ONE_P); // R4
  AST_RD_FULL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_rd_i && !load_i && !inc_wr_i |=> ptr_o == $past(ptr_o) + ONE_A); // R8
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !inc_wr_i && !inc_rd_i |=> $stable(ptr_o)); // R9
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  output logic              any_o,
  output logic              walk_o,
  output logic              done_o,
  output logic              we_o,
  output logic [PAGE_W-1:0] idx_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam logic [PAGE_W-1:0] LAST_IDX = PAGE_W'(PAGE_N - 1);

  logic [PAGE_N-1:0][DATA_W-1:0] slots;
  logic [PAGE_N-1:0]             mask;
  logic                          walk_q, done_q;
  logic [PAGE_W-1:0]             idx_q;

  for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              vld_q;
    logic              hit;
    assign hit = wr_i && (wr_idx_i == PAGE_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  slot_q <= '0;
      else if (hit) slot_q <= wr_data_i;
    end

    // valid mask: one bit per received slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  vld_q <= 1'b0;
      else if (clear_i || done_q)   vld_q <= 1'b0;
      else if (hit)                 vld_q <= 1'b1;
    end

    assign slots[g] = slot_q;
    assign mask[g]  = vld_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      walk_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (walk_q) begin
        idx_q <= idx_q + PAGE_W'(1);
        if (idx_q == LAST_IDX) begin
          walk_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (commit_i) begin
        walk_q <= 1'b1;
        idx_q  <= '0;
      end
    end
  end

  assign any_o  = |mask;
  assign walk_o = walk_q;
  assign done_o = done_q;
  assign idx_o  = idx_q;
  assign we_o   = walk_q && mask[idx_q];
  assign data_o = slots[idx_q];

  AST_BUF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_q |-> !wr_i && !clear_i); // R6
  AST_DONE_AFTER_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(walk_q) && !walk_q); // R7
  AST_COMMIT_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !walk_q |-> any_o); // R6
endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  AST_TMR_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R7
  AST_TMR_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R7
endmodule

// File: rtl/ee_ptr_ctrl.sv
module ee_ptr_ctrl
  import ee_ptr_pkg::*;
#(
  parameter int          PAGE_W    = 4,
  parameter int          WR_CYCLES = 250000,
  parameter logic [3:0]  DEV_CODE  = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        sel_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rd_req_i,
  output logic              ack_o,
  output logic              rd_vld_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  localparam int ADDR_W = BYTE_W;

  seq_st_e           st_q;
  logic              ack_q, rd_vld_q;
  logic [BYTE_W-1:0] rd_data_q;
  logic [ADDR_W-1:0] ptr;
  logic              busy, tmr_busy;
  logic              pb_any, pb_walk, pb_done, pb_we;
  logic [PAGE_W-1:0] pb_idx;
  logic [BYTE_W-1:0] pb_data;
  logic              byte_ev, dev_match;
  logic              ptr_load, inc_wr, inc_rd, buf_clear, commit;

  assign byte_ev   = byte_vld_i && !start_i && !stop_i;
  assign dev_match = (byte_i[7:4] == DEV_CODE) && (byte_i[3:1] == sel_i);
  assign busy      = pb_walk || pb_done || tmr_busy;

  assign ptr_load  = byte_ev && (st_q == ST_WADDR);
  assign inc_wr    = byte_ev && (st_q == ST_WDATA);
  assign inc_rd    = rd_req_i && (st_q == ST_READ);
  assign buf_clear = start_i && !busy;   // repeated start drops pending data
  assign commit    = stop_i && (st_q == ST_WDATA) && pb_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
    end else if (start_i) begin
      st_q <= ST_DEV;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
    end else if (byte_vld_i) begin
      unique case (st_q)
        ST_DEV: begin
          if (dev_match && !busy) begin
            ack_q <= 1'b1;
            st_q  <= byte_i[0] ? ST_READ : ST_WADDR;
          end else begin
            ack_q <= 1'b0;
            st_q  <= ST_IDLE;
          end
        end
        ST_WADDR: begin
          ack_q <= 1'b1;
          st_q  <= ST_WDATA;
        end
        ST_WDATA: ack_q <= 1'b1;
        default:  ack_q <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_vld_q <= inc_rd;
      if (inc_rd) rd_data_q <= mem_rdata_i;
    end
  end

  ee_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (byte_i),
    .inc_wr_i   (inc_wr),
    .inc_rd_i   (inc_rd),
    .ptr_o      (ptr)
  );

  ee_page_buf #(.PAGE_W(PAGE_W), .DATA_W(BYTE_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (buf_clear),
    .wr_i      (inc_wr),
    .wr_idx_i  (ptr[PAGE_W-1:0]),
    .wr_data_i (byte_i),
    .commit_i  (commit),
    .any_o     (pb_any),
    .walk_o    (pb_walk),
    .done_o    (pb_done),
    .we_o      (pb_we),
    .idx_o     (pb_idx),
    .data_o    (pb_data)
  );

  ee_wr_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (pb_done),
    .busy_o  (tmr_busy)
  );

  assign ack_o       = ack_q;
  assign rd_vld_o    = rd_vld_q;
  assign rd_data_o   = rd_data_q;
  assign mem_we_o    = pb_we;
  assign mem_wdata_o = pb_data;
  assign mem_addr_o  = pb_walk ? {ptr[ADDR_W-1:PAGE_W], pb_idx} : ptr;

  AST_BUSY_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ev && (st_q == ST_DEV) && busy |=> !ack_o); // R7
  AST_IDLE_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ev && (st_q == ST_IDLE) |=> !ack_o); // R2
  AST_WE_NOT_IN_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (st_q != ST_WDATA) && (st_q != ST_READ)); // R6
  AST_RD_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> $past(rd_req_i)); // R8
  AST_COMMIT_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pb_walk) |-> $past(stop_i)); // R6
endmodule

// File: tb/ee_ptr_ctrl_bench.sv
module ee_ptr_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WR_CYC     = 40;
  localparam int PAGE_N     = 16;
  localparam logic [2:0] SEL = 3'b101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0, bvld = 1'b0, rd_req = 1'b0;
  logic [7:0] bdat = '0;
  logic       ack, rd_vld, mem_we;
  logic [7:0] rd_data, mem_addr, mem_wdata, mem_rdata;

  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  ee_ptr_ctrl #(.PAGE_W(4), .WR_CYCLES(WR_CYC), .DEV_CODE(4'b1010)) u_ee_ptr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(SEL),
    .start_i(start), .stop_i(stop), .byte_vld_i(bvld), .byte_i(bdat),
    .rd_req_i(rd_req), .ack_o(ack), .rd_vld_o(rd_vld), .rd_data_o(rd_data),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction
  function automatic logic [7:0] nxt_wr(input logic [7:0] p);
    return {p[7:4], p[3:0] + 4'd1};
  endfunction
  function automatic logic [7:0] nxt_rd(input logic [7:0] p);
    return p + 8'd1;
  endfunction
  function automatic logic [7:0] dev(input logic [3:0] code, input logic [2:0] s, input bit rd);
    return {code, s, rd};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask
  task automatic bus_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask
  task automatic send(input logic [7:0] b, output bit a);
    @(negedge clk) begin bdat = b; bvld = 1'b1; end
    @(negedge clk) bvld = 1'b0;
    a = ack;
  endtask
  task automatic read_one(output logic [7:0] d, output bit v);
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    v = rd_vld;
    d = rd_data;
  endtask

  task automatic poll(output bit a);
    bus_start();
    send(dev(4'b1010, SEL, 1'b0), a);
    bus_stop();
  endtask

  // poll until acknowledged; the first poll must be refused
  task automatic wait_ready();
    bit a;
    int n = 0;
    poll(a);
    chk(!a, "R7 first poll after commit", a, 0);
    while (!a && n < 300) begin
      poll(a);
      n++;
    end
    chk(a, "R7 ready after write cycle", a, 1);
  endtask

  task automatic do_write(input logic [7:0] a0, input int n, input bit end_stop);
    bit a;
    logic [7:0] p, d;
    logic [7:0] pend [PAGE_N];
    logic [PAGE_N-1:0] msk = '0;
    bus_start();
    send(dev(4'b1010, SEL, 1'b0), a);
    chk(a, "R2 write device byte ack", a, 1);
    send(a0, a);
    chk(a, "R3 word address ack", a, 1);
    p = a0;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send(d, a);
      chk(a, "R4 data byte ack", a, 1);
      pend[p[3:0]] = d;
      msk[p[3:0]] = 1'b1;
      p = nxt_wr(p);
    end
    exp_ptr = p;
    if (end_stop) begin
      bus_stop();
      if (msk != '0) begin
        for (int k = 0; k < PAGE_N; k++)
          if (msk[k]) exp_mem[{a0[7:4], 4'(k)}] = pend[k];
        wait_ready();
      end
    end
  endtask

  task automatic read_run(input int n, input string req);
    logic [7:0] d;
    bit v;
    for (int i = 0; i < n; i++) begin
      read_one(d, v);
      chk(v && d == exp_mem[exp_ptr], req, d, exp_mem[exp_ptr]);
      exp_ptr = nxt_rd(exp_ptr);
    end
  endtask

  task automatic cur_read(input int n, input string req);
    bit a;
    bus_start();
    send(dev(4'b1010, SEL, 1'b1), a);
    chk(a, "R2 read device byte ack", a, 1);
    read_run(n, req);
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] a0, input int n, input string req);
    bit a;
    bus_start();
    send(dev(4'b1010, SEL, 1'b0), a);
    send(a0, a);
    chk(a, "R10 dummy address ack", a, 1);
    bus_start();
    send(dev(4'b1010, SEL, 1'b1), a);
    chk(a, "R10 read after repeated start ack", a, 1);
    exp_ptr = a0;
    read_run(n, req);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit a;
    int seed_v;
    seed_v = $urandom(32'h5EED_1234);
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_val(i);
      exp_mem[i] = init_val(i);
    end
    exp_ptr = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!ack && !rd_vld && !mem_we, "R1 outputs after reset", {ack, rd_vld, mem_we}, 0);
    cur_read(1, "R1 pointer starts at 00h");

    // R4 row wrap: 20 bytes from 3Ch overwrite the row start
    do_write(8'h3C, 20, 1'b1);
    chk(exp_ptr == 8'h30, "R4 model pointer wrapped in row", exp_ptr, 8'h30);
    cur_read(2, "R9 current read after row write");
    rand_read(8'h30, 16, "R4 row contents after wrap");
    chk(exp_mem[8'h40] == init_val(8'h40), "R4 next row untouched", exp_mem[8'h40], init_val(8'h40));
    rand_read(8'h40, 1, "R4 next row untouched");

    // R5 partial row
    do_write(8'h75, 3, 1'b1);
    rand_read(8'h70, 16, "R5 partial row neighbours");

    // R8 read wrap FFh->00h, then R9 continuation
    rand_read(8'hFD, 5, "R8 read across FFh");
    cur_read(3, "R9 current read after read");

    // R2 mismatched select and wrong code
    bus_start();
    send(dev(4'b1010, SEL ^ 3'b010, 1'b0), a);
    chk(!a, "R2 wrong select nack", a, 0);
    send(8'h10, a);
    chk(!a, "R2 byte after mismatch ignored", a, 0);
    send(8'h55, a);
    chk(!a, "R2 second byte ignored", a, 0);
    bus_stop();
    bus_start();
    send(dev(4'b1011, SEL, 1'b1), a);
    chk(!a, "R2 wrong device code nack", a, 0);
    bus_stop();
    cur_read(2, "R2 pointer kept after ignored bytes");

    // R6 repeated start drops data
    do_write(8'h52, 2, 1'b0);
    cur_read(4, "R6 data dropped on repeated start");

    // R6 stop after address only: no write cycle
    bus_start();
    send(dev(4'b1010, SEL, 1'b0), a);
    send(8'h90, a);
    bus_stop();
    exp_ptr = 8'h90;
    poll(a);
    chk(a, "R6 no busy after address-only write", a, 1);
    cur_read(2, "R9 pointer loaded by address-only write");

    // R7 busy window bounds
    do_write(8'hA4, 2, 1'b0);
    bus_stop();
    exp_mem[8'hA4] = 8'hxx;
    repeat (WR_CYC - 8) @(negedge clk);
    poll(a);
    chk(!a, "R7 still busy before WR_CYCLES", a, 0);
    repeat (PAGE_N + 20) @(negedge clk);
    poll(a);
    chk(a, "R7 ready after deadline", a, 1);
    exp_mem[8'hA4] = mem[8'hA4];
    exp_mem[8'hA5] = mem[8'hA5];
    rand_read(8'hA0, 8, "R5 row after timed write");

    // random mix
    for (int t = 0; t < 60; t++) begin
      int kind = int'($urandom_range(0, 2));
      if (kind == 0) do_write(8'($urandom), int'($urandom_range(1, 20)), 1'b1);
      else if (kind == 1) rand_read(8'($urandom), int'($urandom_range(1, 8)), "R10 random read");
      else cur_read(int'($urandom_range(1, 8)), "R9 random current read");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule